// File: doc/BRIEF.md
# Serial Infrared Pulse Modem

This block sits between a UART and an infrared transceiver on a low-speed link of up to 115.2 kbps. On the transmit side it watches the UART's NRZ output and emits a short light pulse at the start of every zero bit. A one bit leaves the emitter dark. The pulse width has two modes. In the first it is three sixteenths of the bit time, measured in 16x baud ticks. In the second it is a fixed number of system clocks, which software loads with the count that makes up 1.6 µs.

On the receive side the block synchronises the raw detector output and rejects single-clock glitches. Each qualified rising edge pulls the recovered NRZ line low for one full bit time of 16 baud ticks. A UART receiver therefore sees an ordinary frame: a zero start bit, eight data bits sent least significant bit first, and a one stop bit with no parity.

While the modem is disabled, the emitter is held dark and the recovered line idles high.

Top module: `sir_modem`

## Requirements
- R1: After reset, ir_tx is 0 and rx_nrz is 1.
- R2: While mod_en is 0, from the next clock edge ir_tx stays 0 and rx_nrz stays 1 whatever tx_nrz and ir_rx do. The bit-cell timer returns to its idle phase zero.
- R3: The bit-cell timer idles at phase zero. A clock edge where baud_tick is 1, the phase is zero and tx_nrz is 0 starts a pulse, and ir_tx is 1 right after that edge. The timer then counts 16 ticks per cell and wraps back to phase zero.
- R4: A cell start that finds tx_nrz at 1 produces no pulse, and the timer stays at phase zero until it sees a zero.
- R5: With width_sel = 0, a pulse stays high until the third baud tick after its starting tick, so it lasts exactly 3 ticks.
- R6: With width_sel = 1, a pulse lasts fixed_len clock cycles, and a fixed_len of 0 counts as 1. The mode and the length are captured when the pulse starts.
- R7: A frame consists of one zero start bit, eight data bits sent least significant bit first, and one stop bit at 1, each lasting 16 ticks. Such a frame yields exactly 1 + (number of zero data bits) pulses.
- R8: Let edge A be the first clock edge that samples ir_rx high after a low sample, with ir_rx still high at the next edge. Then rx_nrz falls at the third clock edge after edge A. It returns to 1 on the 16th baud tick after falling.
- R9: A new qualified edge while rx_nrz is low restarts the 16-tick window.
- R10: An ir_rx high that is sampled on only one clock edge leaves rx_nrz at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock strobe at 16x the bit rate |
| width_sel | input | 1 | 0: pulse of 3 ticks, 1: pulse of fixed_len clocks |
| fixed_len | input | LEN_W | Pulse length in clocks for fixed mode |
| mod_en | input | 1 | Modem enable |
| tx_nrz | input | 1 | NRZ serial data from the UART transmitter |
| ir_rx | input | 1 | Raw infrared detector output, asynchronous |
| ir_tx | output | 1 | Infrared emitter drive, 1 means light |
| rx_nrz | output | 1 | Recovered NRZ data for the UART receiver |

## Verification
The assertions rely on a few properties of the stimulus.
- ir_rx is held low during reset. The glitch-filter property looks five samples back, and those samples can reach into the reset window.
- baud_tick is a single-cycle strobe.
- tx_nrz changes only on a clock edge that carries a baud tick, as a real UART would do.

The bench keeps to these limits. It derives every tick from one free-running divider and holds ir_rx at 0 until reset is released. Each bit is launched on the clock before a tick, so every bit lasts exactly 16 ticks. Receive pulses are long compared with a clock but short compared with a bit, apart from the single-clock glitches that the filter is there to reject.

// File: rtl/sir_pkg.sv
package sir_pkg;

  typedef enum logic {
    WIDTH_FRACTION = 1'b0,
    WIDTH_FIXED    = 1'b1
  } width_mode_e;

  // Bits needed to hold the values 0..n
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Clock count for a fixed-width pulse; a zero length still lights one clock
  function automatic int fixed_clocks(input int len);
    return (len < 1) ? 1 : len;
  endfunction

endpackage

// File: rtl/sir_cell_timer.sv
module sir_cell_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic tx_nrz,
  output logic cell_start,
  output logic pulse_start
);
  localparam int PW = sir_pkg::cnt_bits(TICKS_PER_BIT - 1);
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_BIT - 1);

  logic [PW-1:0] phase_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] ph);
    return (ph == LAST) ? '0 : ph + 1'b1;
  endfunction

  assign cell_start  = en & tick & (phase_q == '0);
  assign pulse_start = cell_start & ~tx_nrz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!en) begin
      phase_q <= '0;
    end else if (tick) begin
      if (phase_q == '0) begin
        // a one holds the timer in hunt so the next zero re-aligns the cell
        phase_q <= tx_nrz ? '0 : step('0);
      end else begin
        phase_q <= step(phase_q);
      end
    end
  end

endmodule

// File: rtl/sir_pulse_gen.sv
module sir_pulse_gen #(
  parameter int PULSE_TICKS = 3,
  parameter int LEN_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             start,
  input  logic             width_sel,
  input  logic [LEN_W-1:0] fixed_len,
  output logic             ir_tx
);
  import sir_pkg::*;

  localparam int TW = cnt_bits(PULSE_TICKS);

  logic [TW-1:0]    tick_left_q;
  logic [LEN_W-1:0] clk_left_q;
  width_mode_e      mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_tx       <= 1'b0;
      tick_left_q <= '0;
      clk_left_q  <= '0;
      mode_q      <= WIDTH_FRACTION;
    end else if (!en) begin
      ir_tx       <= 1'b0;
      tick_left_q <= '0;
      clk_left_q  <= '0;
    end else if (start) begin
      ir_tx       <= 1'b1;
      mode_q      <= width_mode_e'(width_sel);
      tick_left_q <= TW'(PULSE_TICKS - 1);
      clk_left_q  <= fixed_len;
    end else if (ir_tx) begin
      if (mode_q == WIDTH_FIXED) begin
        if (clk_left_q <= LEN_W'(1)) ir_tx <= 1'b0;
        else                         clk_left_q <= clk_left_q - 1'b1;
      end else if (tick) begin
        if (tick_left_q == '0) ir_tx <= 1'b0;
        else                   tick_left_q <= tick_left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sir_rx_demod.sv
module sir_rx_demod #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic ir_rx,
  output logic edge_ok,
  output logic rx_nrz
);
  localparam int CW = sir_pkg::cnt_bits(TICKS_PER_BIT);

  // [0],[1] synchroniser; [2],[3] history for glitch-qualified edge
  logic [3:0]    sync_q;
  logic [CW-1:0] left_q;

  assign edge_ok = en & sync_q[1] & sync_q[2] & ~sync_q[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      rx_nrz <= 1'b1;
      left_q <= '0;
    end else begin
      sync_q <= {sync_q[2:0], ir_rx};
      if (!en) begin
        rx_nrz <= 1'b1;
        left_q <= '0;
      end else if (edge_ok) begin
        rx_nrz <= 1'b0;
        left_q <= CW'(TICKS_PER_BIT);
      end else if (tick && !rx_nrz) begin
        if (left_q <= CW'(1)) begin
          rx_nrz <= 1'b1;
          left_q <= '0;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sir_modem.sv
module sir_modem #(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_TICKS   = 3,
  parameter int LEN_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             width_sel,
  input  logic [LEN_W-1:0] fixed_len,
  input  logic             mod_en,
  input  logic             tx_nrz,
  input  logic             ir_rx,
  output logic             ir_tx,
  output logic             rx_nrz
);
  // named internal events, visible to the bound checker
  logic cell_start;
  logic pulse_start;
  logic rx_edge_ok;

  sir_cell_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_cell (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (mod_en),
    .tick       (baud_tick),
    .tx_nrz     (tx_nrz),
    .cell_start (cell_start),
    .pulse_start(pulse_start)
  );

  sir_pulse_gen #(.PULSE_TICKS(PULSE_TICKS), .LEN_W(LEN_W)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (mod_en),
    .tick     (baud_tick),
    .start    (pulse_start),
    .width_sel(width_sel),
    .fixed_len(fixed_len),
    .ir_tx    (ir_tx)
  );

  sir_rx_demod #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (mod_en),
    .tick   (baud_tick),
    .ir_rx  (ir_rx),
    .edge_ok(rx_edge_ok),
    .rx_nrz (rx_nrz)
  );

endmodule

// File: rtl/sir_modem_chk.sv
module sir_modem_chk (
  input logic clk,
  input logic rst_n,
  input logic mod_en,
  input logic baud_tick,
  input logic tx_nrz,
  input logic ir_rx,
  input logic ir_tx,
  input logic rx_nrz,
  input logic cell_start
);

  AST_TX_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> !ir_tx); // R2

  AST_RX_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> rx_nrz); // R2

  AST_PULSE_AT_CELL_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> ($past(cell_start) && !$past(tx_nrz))); // R3

  AST_NO_PULSE_FOR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_start && tx_nrz && !ir_tx) |=> !ir_tx); // R4

  AST_RX_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_nrz && mod_en && !baud_tick) |=> !rx_nrz); // R8

  AST_RX_FALL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_nrz) |-> ($past(ir_rx, 3) && $past(ir_rx, 4) && !$past(ir_rx, 5))); // R10

endmodule

bind sir_modem sir_modem_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mod_en    (mod_en),
  .baud_tick (baud_tick),
  .tx_nrz    (tx_nrz),
  .ir_rx     (ir_rx),
  .ir_tx     (ir_tx),
  .rx_nrz    (rx_nrz),
  .cell_start(cell_start)
);

// File: tb/sir_modem_tb.sv
`timescale 1ns/1ps
module sir_modem_tb;
  localparam int TPB = 16;
  localparam int PT  = 3;
  localparam int LW  = 8;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic width_sel = 1'b0, mod_en = 1'b0, tx_nrz = 1'b1, ir_rx = 1'b0;
  logic [LW-1:0] fixed_len = 8'd5;
  logic tick_run = 1'b0;
  int   cyc = 0;
  wire  baud_tick;
  wire  ir_tx, rx_nrz;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign baud_tick = tick_run && (cyc % DIV == 0);

  sir_modem #(.TICKS_PER_BIT(TPB), .PULSE_TICKS(PT), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .width_sel(width_sel),
    .fixed_len(fixed_len), .mod_en(mod_en), .tx_nrz(tx_nrz), .ir_rx(ir_rx),
    .ir_tx(ir_tx), .rx_nrz(rx_nrz)
  );

  int n_checks = 0, n_fail = 0;
  string tx_tag = "R1", rx_tag = "R1";
  bit cmp_on = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_phase, m_tleft, m_cleft, m_rcnt;
  bit m_tx, m_mode, m_rx;
  bit hist[$];

  always @(posedge clk) begin
    bit qual, go;
    if (!rst_n) begin
      m_phase = 0; m_tleft = 0; m_cleft = 0; m_rcnt = 0;
      m_tx = 0; m_mode = 0; m_rx = 1;
      hist = '{0, 0, 0, 0, 0};
    end else begin
      hist.push_front(ir_rx);
      void'(hist.pop_back());
      qual = hist[2] && hist[3] && !hist[4];
      if (!mod_en) begin
        m_phase = 0; m_tx = 0; m_tleft = 0; m_cleft = 0; m_rx = 1; m_rcnt = 0;
      end else begin
        go = baud_tick && (m_phase == 0) && !tx_nrz;
        if (go) begin
          m_tx = 1; m_mode = width_sel; m_tleft = PT;
          m_cleft = (fixed_len == 0) ? 1 : int'(fixed_len);
        end else if (m_tx) begin
          if (m_mode) begin
            m_cleft--;
            if (m_cleft == 0) m_tx = 0;
          end else if (baud_tick) begin
            m_tleft--;
            if (m_tleft == 0) m_tx = 0;
          end
        end
        if (baud_tick) begin
          if (m_phase == 0) m_phase = tx_nrz ? 0 : 1;
          else              m_phase = (m_phase + 1) % TPB;
        end
        if (qual) begin
          m_rx = 0; m_rcnt = TPB;
        end else if (!m_rx && baud_tick) begin
          m_rcnt--;
          if (m_rcnt == 0) m_rx = 1;
        end
      end
    end
  end

  // per-clock comparison and pulse monitors, away from the active edge
  int pulses = 0, hi_len = 0, wmin = 0, wmax = 0, rx_low = 0;
  bit prev_tx = 0;

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      check(ir_tx === m_tx, tx_tag, int'(ir_tx), int'(m_tx));
      check(rx_nrz === m_rx, rx_tag, int'(rx_nrz), int'(m_rx));
    end
    if (ir_tx) begin
      if (!prev_tx) pulses++;
      hi_len++;
    end else if (prev_tx) begin
      if (wmin == 0 || hi_len < wmin) wmin = hi_len;
      if (hi_len > wmax) wmax = hi_len;
      hi_len = 0;
    end
    prev_tx = ir_tx;
    if (rst_n && !rx_nrz) rx_low++;
  end

  task automatic clear_mon();
    pulses = 0; wmin = 0; wmax = 0; rx_low = 0;
  endtask

  task automatic send_frame(input logic [7:0] b);
    logic [9:0] bits;
    bits = {1'b1, b, 1'b0};
    do @(negedge clk); while (baud_tick !== 1'b1);
    for (int i = 0; i < 10; i++) begin
      tx_nrz = bits[i];
      repeat (TPB * DIV) @(negedge clk);
    end
    tx_nrz = 1'b1;
    repeat (2 * TPB * DIV) @(negedge clk);
  endtask

  task automatic frame_test(input logic [7:0] b, input int exp_w, input string wtag);
    int zeros;
    zeros = 0;
    for (int i = 0; i < 8; i++) if (!b[i]) zeros++;
    clear_mon();
    send_frame(b);
    check(pulses == 1 + zeros, (b == 8'hFF) ? "R4" : "R7", pulses, 1 + zeros);
    check(wmin == exp_w, wtag, wmin, exp_w);
    check(wmax == exp_w, wtag, wmax, exp_w);
  endtask

  task automatic rx_pulse(input int width);
    ir_rx = 1'b1;
    repeat (width) @(negedge clk);
    ir_rx = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ir_tx == 1'b0, "R1", int'(ir_tx), 0);
    check(rx_nrz == 1'b1, "R1", int'(rx_nrz), 1);
    tick_run = 1'b1;
    cmp_on   = 1'b1;

    // disabled: zeros on tx and pulses on rx have no effect
    tx_tag = "R2"; rx_tag = "R2";
    clear_mon();
    tx_nrz = 1'b0;
    for (int i = 0; i < 20; i++) begin
      rx_pulse(5);
      repeat (5) @(negedge clk);
    end
    check(pulses == 0, "R2", pulses, 0);
    check(rx_low == 0, "R2", rx_low, 0);
    tx_nrz = 1'b1;
    mod_en = 1'b1;
    repeat (40) @(negedge clk);

    // fractional width frames
    tx_tag = "R3 R5"; rx_tag = "R8";
    width_sel = 1'b0;
    frame_test(8'h59, PT * DIV, "R5");
    frame_test(8'h00, PT * DIV, "R5");
    tx_tag = "R4";
    frame_test(8'hFF, PT * DIV, "R5");
    tx_tag = "R7";
    frame_test(8'hA6, PT * DIV, "R5");

    // fixed width frames
    tx_tag = "R6";
    width_sel = 1'b1;
    fixed_len = 8'd7;
    frame_test(8'h3C, 7, "R6");
    frame_test(8'h81, 7, "R6");
    fixed_len = 8'd0;
    frame_test(8'hF0, 1, "R6");
    width_sel = 1'b0;
    fixed_len = 8'd5;

    // receive: single qualified pulse
    rx_tag = "R8";
    rx_pulse(3);
    repeat (7) @(negedge clk);
    check(rx_nrz == 1'b0, "R8", int'(rx_nrz), 0);
    repeat (50) @(negedge clk);
    check(rx_nrz == 1'b0, "R8", int'(rx_nrz), 0);
    repeat (23) @(negedge clk);
    check(rx_nrz == 1'b1, "R8", int'(rx_nrz), 1);
    repeat (20) @(negedge clk);

    // receive: retrigger inside the window
    rx_tag = "R9";
    rx_pulse(3);
    repeat (37) @(negedge clk);
    rx_pulse(3);
    repeat (37) @(negedge clk);
    check(rx_nrz == 1'b0, "R9", int'(rx_nrz), 0);
    repeat (60) @(negedge clk);
    check(rx_nrz == 1'b1, "R9", int'(rx_nrz), 1);
    repeat (20) @(negedge clk);

    // receive: one-clock glitches are rejected
    rx_tag = "R10";
    clear_mon();
    for (int i = 0; i < 6; i++) begin
      rx_pulse(1);
      repeat (9) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    check(rx_low == 0, "R10", rx_low, 0);

    // receive: back-to-back bit pulses like a byte of zeros
    rx_tag = "R9";
    for (int i = 0; i < 5; i++) begin
      rx_pulse(2);
      repeat (TPB * DIV - 2) @(negedge clk);
    end
    repeat (100) @(negedge clk);

    // disable while a window is open
    rx_tag = "R2"; tx_tag = "R2";
    rx_pulse(3);
    repeat (10) @(negedge clk);
    mod_en = 1'b0;
    @(negedge clk);
    check(rx_nrz == 1'b1, "R2", int'(rx_nrz), 1);
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule